// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block turns a host request (an operation strobe with a direction bit, a byte address and a byte count) into the complete sequence of serial transactions that a serial-interface EEPROM expects. It drives the chip select, clock and data-out lines through an internal mode-0 byte shifter (clock idle low, data changed on the falling edge, sampled on the rising edge, most significant bit first, 8-bit characters). The host supplies payload bytes on `wr_data` when the block pulses `wr_take`, and receives read data as `rd_data` qualified by `rd_valid`.

A write runs as three chained phases: a one-byte enable transaction, a program transaction carrying the opcode, the address and the payload, and then a loop of two-byte status transactions. The loop ends when the in-progress bit of the returned status byte is clear, or with a timeout once the poll limit is used up. Polls are spaced by a wait derived from a clock-frequency parameter, so the same logic serves a real 1 ms interval and a short one. A read is a single transaction: the opcode and address go out, the returned data bytes are passed to the host, and one extra byte is clocked at the end and discarded.

The controller is one state machine with states IDLE, SELECT, LAUNCH, SHIFT, GAP, WAIT and DONE, plus a phase register (ENABLE, PROGRAM, STATUS, FETCH). Transitions: IDLE to SELECT on an accepted strobe; SELECT to LAUNCH after one cycle with chip select low; LAUNCH to SHIFT as a byte starts; SHIFT back to LAUNCH when a byte finishes and more remain, or to GAP after the last byte; GAP, after its fixed count, to SELECT (ENABLE to PROGRAM, PROGRAM to STATUS), to WAIT (status busy, polls left), or to DONE (status clear, poll limit reached, or FETCH finished); WAIT to SELECT when the poll interval expires; DONE to IDLE.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `op_done` and `op_timeout` are 0.
- R2: A write operation (`op_write`=1) starts with a transaction of exactly one byte, 0x06.
- R3: The second transaction of a write is 0x02, then the address bytes most significant first, then the `op_len` payload bytes in the order taken through `wr_take`, all under one chip-select assertion of 1+ADDR_BYTES+`op_len` bytes.
- R4: After the program transaction the block issues status transactions of two bytes, 0x05 then a dummy; bit 0 of the second received byte set means busy; the first poll returning bit 0 clear ends the operation with `op_timeout`=0.
- R5: Between two consecutive status transactions chip select stays high for at least CLK_FREQ_HZ/POLL_RATE_HZ clock cycles.
- R6: If MAX_POLLS status transactions all return bit 0 set, the operation ends with `op_done` and `op_timeout` both 1, and no further transaction is issued.
- R7: A read (`op_write`=0) is one transaction: 0x03, the address bytes, then `op_len`+1 dummy bytes; `rd_valid` pulses exactly `op_len` times carrying the bytes received after the address, and the final extra byte is discarded.
- R8: Chip select stays high exactly 2*SCK_HALF clock cycles between transactions of one operation (apart from poll waits), and `op_done` follows the final chip-select rise by 2*SCK_HALF cycles.
- R9: `spi_sclk` is 0 whenever `spi_cs_n` is 1.
- R10: `op_done` is high for exactly one cycle per operation, and a strobe arriving while `busy` is 1 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Operation strobe, accepted only when idle |
| op_write | input | 1 | 1 = write, 0 = read |
| op_addr | input | 8*ADDR_BYTES | EEPROM byte address |
| op_len | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Payload byte, sampled in the cycle `wr_take` is 1 |
| wr_take | output | 1 | Payload byte consumed this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| op_timeout | output | 1 | With `op_done`: poll limit reached |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
Each byte takes 16*SCK_HALF cycles, and `rd_valid` appears in the cycle right after the last falling clock edge of its byte. Chip select rises in the same edge that ends the final byte, and `op_done` follows exactly 2*SCK_HALF cycles later; a poll gap is 2*SCK_HALF plus the interval plus one cycle. The bench samples every result at the rising edge with inputs changed on the falling edge, counts chip-select high cycles to check the gap, poll spacing and done delay against these figures, and decodes the serial lines with its own EEPROM model, sweeping lengths, addresses and busy-poll counts.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    localparam logic [7:0] OPC_ENABLE  = 8'h06;
    localparam logic [7:0] OPC_PROGRAM = 8'h02;
    localparam logic [7:0] OPC_STATUS  = 8'h05;
    localparam logic [7:0] OPC_FETCH   = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_LAUNCH,
        ST_SHIFT,
        ST_GAP,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_ENABLE,
        PH_PROGRAM,
        PH_STATUS,
        PH_FETCH
    } phase_t;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int SCK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic [3:0]       edge_cnt;
    logic [7:0]       tx_sr;
    logic [7:0]       rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            sclk     <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy     <= 1'b1;
                tx_sr    <= tx_byte;
                div_cnt  <= '0;
                edge_cnt <= '0;
                sclk     <= 1'b0;
            end else if (busy) begin
                if (div_cnt == DIV_W'(SCK_HALF - 1)) begin
                    div_cnt <= '0;
                    sclk    <= ~sclk;
                    if (!sclk) begin
                        rx_sr <= {rx_sr[6:0], miso};
                    end else begin
                        tx_sr <= {tx_sr[6:0], 1'b0};
                    end
                    if (edge_cnt == 4'd15) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                    edge_cnt <= edge_cnt + 4'd1;
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end
        end
    end

    assign mosi    = tx_sr[7];
    assign rx_byte = rx_sr;

    // R9
    shifter_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R10
    shifter_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/poll_interval_timer.sv
module poll_interval_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (arm) begin
                cnt     <= CW'(CYCLES - 1);
                running <= 1'b1;
            end else if (running) begin
                if (cnt == '0) begin
                    running <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    // R5
    no_early_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !expired);

endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
    import eeprom_seq_pkg::*;
#(
    parameter int ADDR_BYTES   = 2,
    parameter int LEN_W        = 9,
    parameter int SCK_HALF     = 4,
    parameter int CLK_FREQ_HZ  = 100_000_000,
    parameter int POLL_RATE_HZ = 1000,
    parameter int MAX_POLLS    = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_start,
    input  logic                    op_write,
    input  logic [ADDR_BYTES*8-1:0] op_addr,
    input  logic [LEN_W-1:0]        op_len,
    input  logic [7:0]              wr_data,
    output logic                    wr_take,
    output logic [7:0]              rd_data,
    output logic                    rd_valid,
    output logic                    busy,
    output logic                    op_done,
    output logic                    op_timeout,
    output logic                    spi_cs_n,
    output logic                    spi_sclk,
    output logic                    spi_mosi,
    input  logic                    spi_miso
);
    localparam int AW          = ADDR_BYTES * 8;
    localparam int POLL_CYCLES = CLK_FREQ_HZ / POLL_RATE_HZ;
    localparam int GAP_CYC     = 2 * SCK_HALF;
    localparam int IDX_W       = LEN_W + $clog2(ADDR_BYTES + 3);
    localparam int PW          = $clog2(MAX_POLLS + 1);
    localparam int GW          = $clog2(GAP_CYC + 1);

    seq_state_t       state, state_nx;
    phase_t           phase;
    logic [AW-1:0]    addr_q;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] idx, last_idx;
    logic [PW-1:0]    poll_cnt;
    logic [GW-1:0]    gap_cnt;
    logic             wip_q, timeout_q;

    logic             sh_start, sh_busy, sh_done;
    logic [7:0]       sh_rx, tx_byte, addr_byte, opcode;
    logic             tmr_arm, tmr_expired;
    logic             gap_end, poll_limit, in_addr, past_addr;

    spi_byte_shifter #(.SCK_HALF(SCK_HALF)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    poll_interval_timer #(.CYCLES(POLL_CYCLES)) u_poll_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (tmr_arm),
        .expired (tmr_expired)
    );

    // Index of the final byte of the current transaction.
    always_comb begin
        unique case (phase)
            PH_ENABLE:  last_idx = '0;
            PH_PROGRAM: last_idx = IDX_W'(ADDR_BYTES) + IDX_W'(len_q);
            PH_STATUS:  last_idx = IDX_W'(1);
            PH_FETCH:   last_idx = IDX_W'(ADDR_BYTES) + IDX_W'(len_q) + IDX_W'(1);
        endcase
    end

    always_comb begin
        unique case (phase)
            PH_ENABLE:  opcode = OPC_ENABLE;
            PH_PROGRAM: opcode = OPC_PROGRAM;
            PH_STATUS:  opcode = OPC_STATUS;
            PH_FETCH:   opcode = OPC_FETCH;
        endcase
    end

    // Address bytes go out most significant first: index 1 picks the top byte.
    always_comb begin
        addr_byte = '0;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            if (idx == IDX_W'(ADDR_BYTES - b)) addr_byte = addr_q[b*8 +: 8];
        end
    end

    assign in_addr   = (idx != '0) && (idx <= IDX_W'(ADDR_BYTES));
    assign past_addr = idx > IDX_W'(ADDR_BYTES);

    always_comb begin
        if (idx == '0)                          tx_byte = opcode;
        else if (in_addr)                       tx_byte = addr_byte;
        else if (phase == PH_PROGRAM)           tx_byte = wr_data;
        else                                    tx_byte = 8'h00;
    end

    assign gap_end    = gap_cnt == GW'(GAP_CYC - 1);
    assign poll_limit = poll_cnt == PW'(MAX_POLLS);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (op_start) state_nx = ST_SELECT;
            ST_SELECT: state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (sh_done) state_nx = (idx == last_idx) ? ST_GAP : ST_LAUNCH;
            end
            ST_GAP: begin
                if (gap_end) begin
                    unique case (phase)
                        PH_ENABLE, PH_PROGRAM: state_nx = ST_SELECT;
                        PH_STATUS: begin
                            if (!wip_q || poll_limit) state_nx = ST_DONE;
                            else                      state_nx = ST_WAIT;
                        end
                        PH_FETCH: state_nx = ST_DONE;
                    endcase
                end
            end
            ST_WAIT:   if (tmr_expired) state_nx = ST_SELECT;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Operation context, byte index, poll and gap counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= PH_ENABLE;
            addr_q    <= '0;
            len_q     <= '0;
            idx       <= '0;
            poll_cnt  <= '0;
            gap_cnt   <= '0;
            wip_q     <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (op_start) begin
                        addr_q    <= op_addr;
                        len_q     <= op_len;
                        phase     <= op_write ? PH_ENABLE : PH_FETCH;
                        poll_cnt  <= '0;
                        wip_q     <= 1'b0;
                        timeout_q <= 1'b0;
                        gap_cnt   <= '0;
                    end
                end
                ST_SELECT: idx <= '0;
                ST_SHIFT: begin
                    if (sh_done) begin
                        idx <= idx + IDX_W'(1);
                        if (phase == PH_STATUS && idx == IDX_W'(1)) begin
                            wip_q    <= sh_rx[0];
                            poll_cnt <= poll_cnt + PW'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_end) begin
                        gap_cnt <= '0;
                        if (phase == PH_ENABLE)  phase <= PH_PROGRAM;
                        if (phase == PH_PROGRAM) phase <= PH_STATUS;
                        if (phase == PH_STATUS && wip_q && poll_limit) timeout_q <= 1'b1;
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        spi_cs_n   = !(state == ST_SELECT || state == ST_LAUNCH || state == ST_SHIFT);
        busy       = state != ST_IDLE;
        op_done    = state == ST_DONE;
        op_timeout = (state == ST_DONE) && timeout_q;
        sh_start   = state == ST_LAUNCH;
        wr_take    = (state == ST_LAUNCH) && (phase == PH_PROGRAM) && past_addr;
        rd_valid   = (state == ST_SHIFT) && sh_done && (phase == PH_FETCH)
                     && past_addr && (idx < last_idx);
        tmr_arm    = (state == ST_GAP) && (state_nx == ST_WAIT);
    end

    assign rd_data = sh_rx;

    // R9
    cs_idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R9
    cs_held_while_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !spi_cs_n);

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R10
    strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done && op_start) |=> busy);

    // R6
    timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_timeout |-> op_done);

    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PW'(MAX_POLLS));

    // R7
    read_under_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n);

endmodule

// File: tb/eeprom_cmd_seq_bench.sv
module eeprom_cmd_seq_bench;
    localparam int AB     = 2;
    localparam int LW     = 4;
    localparam int HALF   = 2;
    localparam int FREQ   = 125_000_000;
    localparam int RATE   = 5_000_000;
    localparam int MAXP   = 4;
    localparam int GAP    = 2 * HALF;
    localparam int POLLC  = FREQ / RATE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, op_write = 1'b0;
    logic [AB*8-1:0] op_addr = '0;
    logic [LW-1:0] op_len = '0;
    logic [7:0] wr_data, rd_data;
    logic wr_take, rd_valid, busy, op_done, op_timeout;
    logic spi_cs_n, spi_sclk, spi_mosi;
    logic miso = 1'b0;
    logic mon_clr = 1'b0;
    logic [7:0] pat_base = 8'h00;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    eeprom_cmd_seq #(
        .ADDR_BYTES(AB), .LEN_W(LW), .SCK_HALF(HALF),
        .CLK_FREQ_HZ(FREQ), .POLL_RATE_HZ(RATE), .MAX_POLLS(MAXP)
    ) u_eeprom_cmd_seq (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_write(op_write),
        .op_addr(op_addr), .op_len(op_len), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .op_done(op_done),
        .op_timeout(op_timeout), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(miso)
    );

    // ---------------- host payload source ----------------
    int wr_idx = 0;
    always @(posedge clk) begin
        if (mon_clr)      wr_idx <= 0;
        else if (wr_take) wr_idx <= wr_idx + 1;
    end
    assign wr_data = pat_base + 8'(wr_idx) * 8'd37;

    // ---------------- monitors ----------------
    logic [7:0] rd_buf [0:15];
    int rd_cnt = 0, done_cycles = 0, done_delay = -1, timeout_seen = 0;
    int cs_hi_run = 0, fall_cnt = 0;
    int gap_log [0:15];
    int clk_cs_violations = 0;
    always @(posedge clk) begin
        if (spi_cs_n && spi_sclk) clk_cs_violations <= clk_cs_violations + 1;
        cs_hi_run <= spi_cs_n ? cs_hi_run + 1 : 0;
        if (mon_clr) begin
            rd_cnt <= 0; done_cycles <= 0; done_delay <= -1;
            timeout_seen <= 0; fall_cnt <= 0;
        end else begin
            if (rd_valid) begin
                if (rd_cnt < 16) rd_buf[rd_cnt] <= rd_data;
                rd_cnt <= rd_cnt + 1;
            end
            if (op_done) begin
                done_cycles <= done_cycles + 1;
                if (done_cycles == 0) done_delay <= cs_hi_run;
                if (op_timeout) timeout_seen <= 1;
            end
            if (!spi_cs_n && cs_hi_run > 0) begin
                if (fall_cnt < 16) gap_log[fall_cnt] <= cs_hi_run;
                fall_cnt <= fall_cnt + 1;
            end
        end
    end

    // ---------------- EEPROM model ----------------
    logic [7:0] mem [0:63];
    logic [7:0] in_sr = '0, out_sr = '0, s_opc = '0;
    logic [15:0] s_addr = '0;
    logic wel = 1'b0, in_txn = 1'b0;
    int bit_cnt = 0, byte_cnt = 0, txn_cnt = 0, busy_left = 0, busy_cfg = 0;
    logic [7:0] log_opc [0:63];
    int log_len [0:63];

    always @(negedge spi_cs_n) begin
        bit_cnt = 0; byte_cnt = 0; out_sr = '0; miso = 1'b0; in_txn = 1'b1;
    end

    always @(posedge spi_cs_n) begin
        if (in_txn) begin
            in_txn = 1'b0;
            log_opc[txn_cnt % 64] = s_opc;
            log_len[txn_cnt % 64] = byte_cnt;
            txn_cnt = txn_cnt + 1;
            if (s_opc == 8'h06 && byte_cnt == 1) wel = 1'b1;
            if (s_opc == 8'h02 && byte_cnt > 2 && wel) begin
                wel = 1'b0;
                busy_left = busy_cfg;
            end
        end
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            in_sr = {in_sr[6:0], spi_mosi};
            bit_cnt = bit_cnt + 1;
            if (bit_cnt % 8 == 0) begin
                if (byte_cnt == 0) s_opc = in_sr;
                else if (byte_cnt <= AB) s_addr = {s_addr[7:0], in_sr};
                else if (s_opc == 8'h02 && wel)
                    mem[6'(s_addr + 16'(byte_cnt) - 16'(AB + 1))] = in_sr;
                byte_cnt = byte_cnt + 1;
                out_sr = 8'h00;
                if (s_opc == 8'h05 && byte_cnt == 1) begin
                    out_sr = {7'd0, busy_left > 0};
                    if (busy_left > 0) busy_left = busy_left - 1;
                end else if (s_opc == 8'h03 && byte_cnt > AB) begin
                    out_sr = mem[6'(s_addr + 16'(byte_cnt) - 16'(AB + 1))];
                end
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            miso = out_sr[7];
            out_sr = {out_sr[6:0], 1'b0};
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input bit wr, input int addr, input int len, input int sneak_at);
        @(negedge clk);
        op_write = wr; op_addr = 16'(addr); op_len = LW'(len);
        op_start = 1'b1; mon_clr = 1'b1;
        @(negedge clk);
        op_start = 1'b0; mon_clr = 1'b0;
        // optional extra strobe while busy, with a different request
        if (sneak_at > 0) begin
            repeat (sneak_at) @(negedge clk);
            op_write = ~wr; op_addr = 16'(addr + 9); op_len = LW'(1);
            op_start = 1'b1;
            @(negedge clk);
            op_start = 1'b0;
        end
        for (int w = 0; w < 5000 && done_cycles == 0; w++) @(negedge clk);
        chk(done_cycles > 0, "R10", "operation completed", done_cycles, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input int addr, input int len, input int bpolls,
                            input int sneak_at);
        int t0, npoll, exp_polls;
        bit exp_to;
        busy_cfg = bpolls;
        pat_base = 8'(addr * 3 + len);
        t0 = txn_cnt;
        launch(1'b1, addr, len, sneak_at);
        exp_to = bpolls >= MAXP;
        exp_polls = exp_to ? MAXP : bpolls + 1;
        npoll = txn_cnt - t0 - 2;
        chk(log_opc[t0 % 64] == 8'h06, "R2", "first opcode", int'(log_opc[t0 % 64]), 6);
        chk(log_len[t0 % 64] == 1, "R2", "enable length", log_len[t0 % 64], 1);
        chk(log_opc[(t0 + 1) % 64] == 8'h02, "R3", "program opcode",
            int'(log_opc[(t0 + 1) % 64]), 2);
        chk(log_len[(t0 + 1) % 64] == 1 + AB + len, "R3", "program length",
            log_len[(t0 + 1) % 64], 1 + AB + len);
        for (int i = 0; i < len; i++)
            chk(mem[6'(addr + i)] == 8'(pat_base + 8'(i) * 8'd37), "R3", "stored payload",
                int'(mem[6'(addr + i)]), int'(8'(pat_base + 8'(i) * 8'd37)));
        if (exp_to) chk(npoll == exp_polls, "R6", "poll count at limit", npoll, exp_polls);
        else        chk(npoll == exp_polls, "R4", "poll count", npoll, exp_polls);
        for (int p = 0; p < npoll && p < 8; p++) begin
            chk(log_opc[(t0 + 2 + p) % 64] == 8'h05 && log_len[(t0 + 2 + p) % 64] == 2,
                "R4", "status transaction shape", log_len[(t0 + 2 + p) % 64], 2);
        end
        if (exp_to) chk(timeout_seen == 1, "R6", "timeout flag", timeout_seen, 1);
        else        chk(timeout_seen == 0, "R4", "timeout flag", timeout_seen, 0);
        chk(gap_log[1] == GAP, "R8", "gap enable->program", gap_log[1], GAP);
        chk(gap_log[2] == GAP, "R8", "gap program->status", gap_log[2], GAP);
        for (int p = 3; p < fall_cnt && p < 16; p++)
            chk(gap_log[p] >= POLLC, "R5", "poll spacing", gap_log[p], POLLC);
        chk(done_cycles == 1, "R10", "done width", done_cycles, 1);
        chk(done_delay == GAP, "R8", "done delay", done_delay, GAP);
    endtask

    task automatic do_read(input int addr, input int len);
        int t0;
        t0 = txn_cnt;
        launch(1'b0, addr, len, 0);
        chk(txn_cnt - t0 == 1, "R7", "read transaction count", txn_cnt - t0, 1);
        chk(log_opc[t0 % 64] == 8'h03, "R7", "read opcode", int'(log_opc[t0 % 64]), 3);
        chk(log_len[t0 % 64] == 1 + AB + len + 1, "R7", "read length",
            log_len[t0 % 64], 1 + AB + len + 1);
        chk(rd_cnt == len, "R7", "rd_valid count", rd_cnt, len);
        for (int i = 0; i < len; i++)
            chk(rd_buf[i] == mem[6'(addr + i)], "R7", "read byte",
                int'(rd_buf[i]), int'(mem[6'(addr + i)]));
        chk(done_cycles == 1, "R10", "done width", done_cycles, 1);
        chk(done_delay == GAP, "R8", "done delay", done_delay, GAP);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int t_mark;
        for (int i = 0; i < 64; i++) mem[i] = 8'hA5;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", int'(spi_cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "serial idle",
            int'({spi_cs_n, spi_sclk}), 2);
        chk(busy == 1'b0 && op_done == 1'b0 && op_timeout == 1'b0, "R1", "flags idle",
            int'({busy, op_done, op_timeout}), 0);

        // Sweep: lengths, addresses, busy-poll counts; each write read back
        for (int len = 1; len <= 4; len++) begin
            for (int a = 0; a < 3; a++) begin
                int addr;
                addr = (a == 0) ? 0 : (a == 1) ? 17 : 40;
                do_write(addr, len, (len + a) % 3, 0);
                do_read(addr, len);
            end
        end

        // R6: device never leaves busy
        do_write(8, 2, 100, 0);
        t_mark = txn_cnt;
        repeat (200) @(negedge clk);
        chk(txn_cnt == t_mark, "R6", "no traffic after timeout", txn_cnt - t_mark, 0);

        // R10: strobe during an operation is ignored
        do_write(24, 3, 1, 40);
        t_mark = txn_cnt;
        repeat (300) @(negedge clk);
        chk(txn_cnt == t_mark && busy == 1'b0, "R10", "ignored strobe traffic",
            txn_cnt - t_mark, 0);
        do_read(24, 3);
        do_read(20, 1);

        // R9: clock idle whenever chip select is high
        chk(clk_cs_violations == 0, "R9", "sclk high with cs_n high", clk_cs_violations, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule